// File: doc/BRIEF.md
# Calibration-Pattern Read Responder

This block models the memory-side behaviour of a DDR3-style device while its multi-purpose register mode is active. It watches the command bus for mode-register-set commands aimed at mode register 3. Bit 2 of that command switches calibration mode on or off. While the mode is on, every READ is redirected away from the array. Each READ returns a fixed 8-beat calibration burst that begins after the read latency AL + CL. A controller uses these bursts to train its read-capture timing before normal traffic starts.

Reads that follow each other closely are queued, so their bursts leave in command order with no gap between them. The block raises three one-cycle violation pulses: one for a write issued during calibration mode, one for a read issued too soon after the enabling command (tMOD), and one for leaving the mode too soon after the last burst (tMPRR). Data leaves on a valid/data stream. That stream has no ready input: a DRAM cannot be stalled, so the receiver must take every beat in the cycle it is presented. Array storage, refresh and electrical timing are not modelled.

Top module: `mpr_responder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mpr_on`, `rd_valid`, `rd_data` and all three violation outputs are 0.
- R2: A command with `cmd_valid`=1, `cmd_op`=1 (MRS), `cmd_bank`=3 (mode register 3), `cmd_addr[2]`=1 and `cmd_addr[1:0]`=00 sets `mpr_on` from the next cycle. An MRS with `cmd_addr[2]`=1 and a nonzero `cmd_addr[1:0]`, or an MRS to any other bank, leaves `mpr_on` unchanged.
- R3: An MRS to bank 3 with `cmd_addr[2]`=0 clears `mpr_on` from the next cycle, whatever the rest of the address holds.
- R4: A READ (`cmd_op`=2) sampled at clock edge k while `mpr_on`=1 produces exactly 8 consecutive cycles of `rd_valid`=1. When no earlier burst is still outstanding, the first of these cycles is the one that follows edge k+AL+CL.
- R5: In beat b of a burst (b = 0 to 7), every bit of `rd_data` equals b mod 2, so the beats read 0,1,0,1,0,1,0,1. `rd_data` is 0 whenever `rd_valid` is 0.
- R6: A burst whose latency has expired while an earlier burst is still running starts in the cycle right after the earlier burst's eighth beat. Bursts leave in command order.
- R7: A READ while `mpr_on`=0 produces no burst and no violation. In calibration mode, `cmd_bank` and all address bits are ignored for reads.
- R8: A WRITE (`cmd_op`=3) sampled while `mpr_on`=1 pulses `viol_wr` for one cycle in the next cycle. A WRITE while `mpr_on`=0 does not.
- R9: A READ sampled fewer than T_MOD edges after the enabling MRS pulses `viol_rd` for one cycle in the next cycle. The burst is still delivered.
- R10: An MRS that leaves calibration mode pulses `viol_exit` in the next cycle if either of these holds: a burst is queued or still running, or fewer than T_MPRR edges have passed since the edge that ends the last burst's final beat. The mode is cleared in either case.
- R11: With `cmd_valid`=0, or with `cmd_op`=0 (NOP), the mode does not change and no violation is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 NOP, 1 MRS, 2 READ, 3 WRITE |
| cmd_bank | input | BANK_W | Bank address; selects the mode register for an MRS |
| cmd_addr | input | ADDR_W | Address / MRS opcode bits |
| mpr_on | output | 1 | Calibration mode is active |
| rd_valid | output | 1 | Stream valid, high for each burst beat |
| rd_data | output | DQ_W | Stream data, pattern bit replicated on all lanes |
| viol_wr | output | 1 | Write issued during calibration mode |
| viol_rd | output | 1 | Read issued before tMOD expired |
| viol_exit | output | 1 | Mode left before tMPRR expired or while bursts outstanding |

## Verification
The bench builds the block with DQ_W=4, AL=1, CL=4, T_MOD=6, T_MPRR=3 and Q_DEPTH=4. With windows this short, both sides of the tMOD and tMPRR boundaries can be hit in directed sequences a few cycles long. Reads spaced four cycles apart arrive faster than 8-beat bursts can drain, which fills the burst queue and tests the no-gap ordering. Random traffic then mixes enables, exits, stray MRS commands, writes and reads against a cycle-indexed model of the expected stream.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_MRS = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } op_e;

  localparam int MR3_BANK  = 3;
  localparam int BURST_LEN = 8;
  localparam int BEAT_W    = $clog2(BURST_LEN);
endpackage

// File: rtl/mpr_mode_ctrl.sv
module mpr_mode_ctrl
  import mpr_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int T_MOD  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [2:0]        cmd_addr_lo,
  input  logic              sched_quiet,
  output logic              mode_on,
  output logic              rd_go,
  output logic              viol_wr,
  output logic              viol_rd,
  output logic              viol_exit
);
  localparam int MW = $clog2(T_MOD + 1);

  logic          is_mr3, enter, leave, is_rd, is_wr;
  logic [MW-1:0] mod_cnt;

  always_comb begin
    is_mr3 = cmd_valid && (cmd_op == OP_MRS) && (cmd_bank == BANK_W'(MR3_BANK));
    // R2: enable only when the pattern location field is 00
    enter  = is_mr3 && cmd_addr_lo[2] && (cmd_addr_lo[1:0] == 2'b00);
    // R3: bit 2 clear leaves the mode
    leave  = is_mr3 && !cmd_addr_lo[2];
    is_rd  = cmd_valid && (cmd_op == OP_RD);
    is_wr  = cmd_valid && (cmd_op == OP_WR);
    // R7: reads outside the mode are not serviced here
    rd_go  = is_rd && mode_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_on   <= 1'b0;
      mod_cnt   <= '0;
      viol_wr   <= 1'b0;
      viol_rd   <= 1'b0;
      viol_exit <= 1'b0;
    end else begin
      if (enter)      mode_on <= 1'b1;
      else if (leave) mode_on <= 1'b0;

      if (enter)              mod_cnt <= MW'(T_MOD - 1);
      else if (mod_cnt != 0)  mod_cnt <= mod_cnt - 1'b1;

      viol_wr   <= is_wr && mode_on;                    // R8
      viol_rd   <= rd_go && (mod_cnt != 0);             // R9
      viol_exit <= leave && mode_on && !sched_quiet;    // R10
    end
  end
endmodule

// File: rtl/mpr_burst_sched.sv
module mpr_burst_sched
  import mpr_pkg::*;
#(
  parameter int RL      = 5,
  parameter int Q_DEPTH = 4,
  parameter int T_MPRR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  output logic              busy,
  output logic [BEAT_W-1:0] beat,
  output logic              quiet
);
  localparam int PW = $clog2(Q_DEPTH + 1);
  localparam int TW = $clog2(T_MPRR + 1);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

  logic [RL-1:0] dly;
  logic [PW-1:0] pend;
  logic [TW-1:0] gap_cnt;
  logic          arrival, load, can_start, take;

  // latency line: one bit per cycle of AL + CL
  generate
    if (RL == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (!rst_n) dly <= '0;
        else        dly <= rd_go;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (!rst_n) dly <= '0;
        else        dly <= {dly[RL-2:0], rd_go};
      end
    end
  endgenerate

  always_comb begin
    arrival   = dly[RL-1];
    load      = arrival || (pend != '0);
    can_start = !busy || (beat == LAST);
    take      = can_start && load;
    quiet     = !busy && (dly == '0) && (pend == '0) && (gap_cnt == '0);
  end

  // R4 R6: bursts chain back to back in arrival order
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      beat    <= '0;
      pend    <= '0;
      gap_cnt <= '0;
    end else begin
      if (take) begin
        busy <= 1'b1;
        beat <= '0;
      end else if (can_start) begin
        busy <= 1'b0;
        beat <= '0;
      end else begin
        beat <= beat + 1'b1;
      end

      pend <= pend + PW'(arrival) - PW'(take);

      // R10: quiet window after the final beat
      if (busy && can_start && !load) gap_cnt <= TW'(T_MPRR - 1);
      else if (gap_cnt != '0)         gap_cnt <= gap_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/mpr_pattern_gen.sv
module mpr_pattern_gen
  import mpr_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  logic              valid,
  input  logic [BEAT_W-1:0] beat,
  output logic [DQ_W-1:0]   data
);
  logic unused_beat_hi;
  assign unused_beat_hi = ^beat[BEAT_W-1:1];

  // R5: alternating pattern, same bit on every lane
  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    assign data[i] = valid & beat[0];
  end
endmodule

// File: rtl/mpr_responder.sv
module mpr_responder
  import mpr_pkg::*;
#(
  parameter int DQ_W    = 8,
  parameter int BANK_W  = 3,
  parameter int ADDR_W  = 16,
  parameter int AL      = 0,
  parameter int CL      = 5,
  parameter int T_MOD   = 12,
  parameter int T_MPRR  = 1,
  parameter int Q_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              mpr_on,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              viol_wr,
  output logic              viol_rd,
  output logic              viol_exit
);
  localparam int RL = AL + CL;

  logic              rd_go, sched_quiet;
  logic [BEAT_W-1:0] beat;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^cmd_addr[ADDR_W-1:3];

  mpr_mode_ctrl #(.BANK_W(BANK_W), .T_MOD(T_MOD)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr_lo(cmd_addr[2:0]), .sched_quiet(sched_quiet),
    .mode_on(mpr_on), .rd_go(rd_go),
    .viol_wr(viol_wr), .viol_rd(viol_rd), .viol_exit(viol_exit)
  );

  mpr_burst_sched #(.RL(RL), .Q_DEPTH(Q_DEPTH), .T_MPRR(T_MPRR)) u_sched (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go),
    .busy(rd_valid), .beat(beat), .quiet(sched_quiet)
  );

  mpr_pattern_gen #(.DQ_W(DQ_W)) u_pat (
    .valid(rd_valid), .beat(beat), .data(rd_data)
  );
endmodule

// File: rtl/mpr_responder_chk.sv
module mpr_responder_chk
  import mpr_pkg::*;
#(
  parameter int DQ_W   = 8,
  parameter int BANK_W = 3,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              mpr_on,
  input logic              rd_valid,
  input logic [DQ_W-1:0]   rd_data,
  input logic              viol_wr,
  input logic              viol_rd,
  input logic              viol_exit
);
  logic [2:0] ph;
  logic       rv_q, rd_q;
  logic       unused_chk;
  logic       mr3;

  assign unused_chk = ^cmd_addr[ADDR_W-1:3] ^ viol_exit;
  assign mr3 = cmd_valid && (cmd_op == OP_MRS) && (cmd_bank == BANK_W'(MR3_BANK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      rv_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      if (rd_valid) ph <= ph + 1'b1;
      rv_q <= rd_valid;
      rd_q <= cmd_valid && (cmd_op == OP_RD) && mpr_on;
    end
  end

  // R2
  mr3_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr3 && cmd_addr[2:0] == 3'b100) |=> mpr_on);
  // R3
  mr3_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr3 && !cmd_addr[2]) |=> !mpr_on);
  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mr3 |=> $stable(mpr_on));
  // R8
  wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WR && mpr_on) |=> viol_wr);
  // R8
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == OP_WR && mpr_on) |=> !viol_wr);
  // R9
  rd_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_rd |-> rd_q);
  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !rd_valid) |-> (ph == 3'd0));
  // R5
  pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == (rd_valid ? {DQ_W{ph[0]}} : {DQ_W{1'b0}}));
endmodule

bind mpr_responder mpr_responder_chk #(.DQ_W(DQ_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .mpr_on(mpr_on),
  .rd_valid(rd_valid), .rd_data(rd_data), .viol_wr(viol_wr),
  .viol_rd(viol_rd), .viol_exit(viol_exit)
);

// File: tb/test_mpr_responder.sv
module test_mpr_responder;
  import mpr_pkg::*;
  localparam int DQ_W = 4, AL = 1, CL = 4, RL = AL + CL;
  localparam int T_MOD = 6, T_MPRR = 3, Q_DEPTH = 4, EXP_N = 4096;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, cmd_valid;
  logic [1:0]      cmd_op;
  logic [2:0]      cmd_bank;
  logic [15:0]     cmd_addr;
  logic            mpr_on, rd_valid, viol_wr, viol_rd, viol_exit;
  logic [DQ_W-1:0] rd_data;

  mpr_responder #(.DQ_W(DQ_W), .BANK_W(3), .ADDR_W(16), .AL(AL), .CL(CL),
                  .T_MOD(T_MOD), .T_MPRR(T_MPRR), .Q_DEPTH(Q_DEPTH)) i_mpr_responder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .mpr_on(mpr_on),
    .rd_valid(rd_valid), .rd_data(rd_data), .viol_wr(viol_wr),
    .viol_rd(viol_rd), .viol_exit(viol_exit)
  );

  int checks = 0, errors = 0, n = 0;
  bit exp_v [EXP_N];
  int exp_ph [EXP_N];
  bit m_on = 0, any_b = 0;
  int m_mod = -1000, nf = 0, last_rd = -100;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // model of one command sampled at edge n+1, then checks after that edge
  task automatic step(input bit vld, input logic [1:0] op, input logic [2:0] bank,
                      input logic [15:0] addr);
    int k, s;
    bit e_wr, e_rd, e_ex;
    logic [DQ_W-1:0] ed;
    k = n + 1;
    e_wr = vld && op == OP_WR && m_on;
    e_rd = vld && op == OP_RD && m_on && (k - m_mod) < T_MOD;
    e_ex = 0;
    if (vld && op == OP_RD) begin
      last_rd = k;
      if (m_on) begin
        s = (k + RL > nf) ? k + RL : nf;
        for (int b = 0; b < 8; b++) begin
          exp_v[s + b]  = 1;
          exp_ph[s + b] = b;
        end
        nf = s + 8;
        any_b = 1;
      end
    end
    if (vld && op == OP_MRS && bank == 3'd3) begin
      if (!addr[2]) begin
        if (m_on && any_b && k < nf + T_MPRR) e_ex = 1;
        m_on = 0;
      end else if (addr[1:0] == 2'b00) begin
        m_on = 1;
        m_mod = k;
      end
    end
    cmd_valid = vld; cmd_op = op; cmd_bank = bank; cmd_addr = addr;
    @(negedge clk);
    n = k;
    ed = (exp_v[n] && exp_ph[n][0]) ? {DQ_W{1'b1}} : {DQ_W{1'b0}};
    chk(rd_valid == exp_v[n], "R4", "rd_valid", rd_valid, exp_v[n]);
    chk(rd_data == ed, "R5", "rd_data", rd_data, ed);
    chk(mpr_on == m_on, "R2", "mpr_on", mpr_on, m_on);
    chk(viol_wr == e_wr, "R8", "viol_wr", viol_wr, e_wr);
    chk(viol_rd == e_rd, "R9", "viol_rd", viol_rd, e_rd);
    chk(viol_exit == e_ex, "R10", "viol_exit", viol_exit, e_ex);
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) step(0, OP_NOP, 3'd0, 16'd0);
  endtask

  task automatic wait_to(input int edge_k);
    while (n + 1 < edge_k) step(0, OP_NOP, 3'd0, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    rst_n = 0; cmd_valid = 0; cmd_op = OP_NOP; cmd_bank = 0; cmd_addr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mpr_on && !rd_valid && rd_data == 0, "R1", "mode/stream", {mpr_on, rd_valid}, 0);
    chk(!viol_wr && !viol_rd && !viol_exit, "R1", "violations", {viol_wr, viol_rd, viol_exit}, 0);
    rst_n = 1;
    n = 0;

    // R7 read outside the mode: no burst; R11 idle cycles
    step(1, OP_RD, 3'd5, 16'h0000);
    idle(RL + 10);
    // R8 write outside the mode: no flag
    step(1, OP_WR, 3'd1, 16'h0010);
    idle(2);
    // R2 wrong location field and wrong bank leave the mode off
    step(1, OP_MRS, 3'd3, 16'h0005);
    step(1, OP_MRS, 3'd2, 16'h0004);
    idle(1);
    // R2 enable, R9 early read still bursts
    step(1, OP_MRS, 3'd3, 16'h0004);
    idle(1);
    step(1, OP_RD, 3'd0, 16'h0000);
    idle(20);
    // R9 read exactly at T_MOD: no flag
    step(1, OP_MRS, 3'd3, 16'hF004);
    idle(T_MOD - 1);
    step(1, OP_RD, 3'd0, 16'h1000);
    // R6 reads four apart queue without gaps; R7 bank and A10 ignored
    idle(3);
    step(1, OP_RD, 3'd7, 16'h0400);
    idle(3);
    step(1, OP_RD, 3'd2, 16'hFFFF);
    // R8 write in the mode
    step(1, OP_WR, 3'd4, 16'h0000);
    idle(40);
    // R10 exit one edge early, then R3 exit exactly on time
    step(1, OP_RD, 3'd0, 16'h0000);
    wait_to(nf + T_MPRR - 1);
    step(1, OP_MRS, 3'd3, 16'h0000);
    step(1, OP_MRS, 3'd3, 16'h0004);
    idle(T_MOD);
    step(1, OP_RD, 3'd0, 16'h0000);
    wait_to(nf + T_MPRR);
    step(1, OP_MRS, 3'd3, 16'h0003);
    // R10 exit while a burst is in flight; exit while off is not flagged
    step(1, OP_MRS, 3'd3, 16'h0004);
    idle(T_MOD);
    step(1, OP_RD, 3'd0, 16'h0000);
    idle(2);
    step(1, OP_MRS, 3'd3, 16'h0000);
    idle(15);
    step(1, OP_MRS, 3'd3, 16'h0000);
    idle(2);

    // constrained random traffic
    for (int i = 0; i < 1500; i++) begin
      r = $urandom % 100;
      if (r < 35 && (n + 1 - last_rd) >= 4 && (nf - (n + 1)) <= RL + 16)
        step(1, OP_RD, 3'($urandom), 16'($urandom));
      else if (r < 45)
        step(1, OP_WR, 3'($urandom), 16'($urandom));
      else if (r < 52)
        step(1, OP_MRS, 3'd3, {13'($urandom), 3'b100});
      else if (r < 55)
        step(1, OP_MRS, 3'd3, 16'($urandom) & 16'hFFFB);
      else if (r < 58)
        step(1, OP_MRS, 3'($urandom), 16'($urandom));
      else
        step(($urandom % 2) == 0, OP_NOP, 3'($urandom), 16'($urandom));
    end
    idle(40);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule